// File: doc/BRIEF.md
# Block-Output Write Phase Aligner

This block sits beside an 8-bit CPU that runs two T-states for every phase of a shared system bus clock. A peripheral I/O write only reaches the external hardware when its strobe begins on an even T-state. Almost every instruction already meets that rule. The few repeating and non-repeating block-output instructions do not: their I/O write machine cycle begins one T-state late.

The block watches the opcode fetches on the CPU bus to find those instructions. When one of them starts its I/O write while the phase reference shows an odd T-state, the block pulls the active-low WAIT input of the CPU low for a single clock. That extra T-state moves the write onto an even T-state. The instruction still does the same work. All other bus cycles pass through with WAIT left high.

Top module: `io_write_aligner`

## Requirements
- R1: While `rstN` is low, `waitN` is high. Reset clears any prefix or trap state, so a write after reset with no new fetch gets no wait.
- R2: An opcode fetch is a bus cycle with `m1N`, `mreqN` and `rdN` all low, and it is counted once at its first clock. A fetch of 0xED followed directly by a fetch of 0xA3, 0xAB, 0xB3 or 0xBB arms the trap. If an I/O write then starts while the trap is armed and `phaseOdd` is 1, `waitN` is low in the clock that follows the first write clock. An I/O write is `iorqN` and `wrN` low with `m1N` high.
- R3: Each such wait lasts exactly one clock, even when the write strobe is held for several clocks.
- R4: A trapped write that starts while `phaseOdd` is 0 gets no wait.
- R5: A prefixed opcode outside the four trapped values, such as 0x41 or 0x79 after 0xED, gets no wait on its write.
- R6: A trapped value fetched without a 0xED fetch directly before it does not arm the trap. A fetch of another opcode between 0xED and the trapped value also prevents the trap.
- R7: A repeating instruction re-fetches 0xED and its opcode on every iteration, and each iteration's odd-phase write gets its own one-clock wait.
- R8: Any other opcode fetch disarms the trap, so later writes get no wait.
- R9: An interrupt acknowledge cycle, with `m1N` and `iorqN` both low, never causes a wait, even while the trap is armed.
- R10: A reset that arrives between the trapped fetch and its write cancels the wait.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | CPU clock, one T-state per cycle |
| rstN | input | 1 | Asynchronous reset, active low |
| m1N | input | 1 | Opcode-fetch / acknowledge marker, active low |
| mreqN | input | 1 | Memory request, active low |
| iorqN | input | 1 | I/O request, active low |
| rdN | input | 1 | Read strobe, active low |
| wrN | input | 1 | Write strobe, active low |
| dataIn | input | 8 | CPU data bus |
| phaseOdd | input | 1 | 1 when the current T-state is odd relative to the bus phase |
| waitN | output | 1 | Wait request to the CPU, active low |

## Verification
The bench runs the single-step output instructions with their write on an odd T-state and on an even T-state. This separates the phase test from the opcode test. Repeating instructions over several iterations show that the trap re-arms on each new fetch. Plain prefixed outputs, the bare trapped byte with no prefix, and a prefix broken by another fetch show that nothing else stalls. Held write strobes, interrupt acknowledges during an armed trap, and a reset between fetch and write cover the remaining ways a stray or repeated wait could appear.

// File: rtl/io_write_aligner_pkg.sv
package io_write_aligner_pkg;

  typedef enum logic [1:0] {
    ST_IDLE   = 2'd0,
    ST_PREFIX = 2'd1,
    ST_ARMED  = 2'd2
  } trapState_t;

  // strobes from control to datapath
  typedef struct packed {
    logic startWait;
    logic clearWait;
  } ctrlStrobes_t;

endpackage

// File: rtl/io_write_aligner_dp.sv
module io_write_aligner_dp
  import io_write_aligner_pkg::*;
#(
  parameter int          DATA_W     = 8,
  parameter logic [7:0]  PREFIX_OP  = 8'hED,
  parameter logic [7:0]  TRAP_MATCH = 8'hA3,
  parameter logic [7:0]  TRAP_MASK  = 8'hE7,
  parameter logic        ODD_LEVEL  = 1'b1
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              m1N,
  input  logic              mreqN,
  input  logic              iorqN,
  input  logic              rdN,
  input  logic              wrN,
  input  logic [DATA_W-1:0] dataIn,
  input  logic              phaseOdd,
  input  ctrlStrobes_t      strobes,
  output logic              fetchStart,
  output logic              ioWrStart,
  output logic              opIsPrefix,
  output logic              opIsTrap,
  output logic              phaseIsOdd,
  output logic              waitN
);

  localparam int CMP_W = (DATA_W < 8) ? DATA_W : 8;

  logic fetchActive;
  logic ioWrActive;
  logic fetchPrev;
  logic ioWrPrev;
  logic waitReg;

  // opcode fetch: M1 with a memory read; acknowledge has no MREQ
  assign fetchActive = !m1N && !mreqN && !rdN;
  // peripheral write: acknowledge cycles carry M1 and are excluded
  assign ioWrActive  = m1N && !iorqN && !wrN;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      fetchPrev <= 1'b0;
      ioWrPrev  <= 1'b0;
    end else begin
      fetchPrev <= fetchActive;
      ioWrPrev  <= ioWrActive;
    end
  end

  assign fetchStart = fetchActive && !fetchPrev;
  assign ioWrStart  = ioWrActive && !ioWrPrev;
  assign phaseIsOdd = (phaseOdd == ODD_LEVEL);

  assign opIsPrefix = (dataIn[CMP_W-1:0] == PREFIX_OP[CMP_W-1:0]);
  assign opIsTrap   = ((dataIn[CMP_W-1:0] & TRAP_MASK[CMP_W-1:0]) ==
                       (TRAP_MATCH[CMP_W-1:0] & TRAP_MASK[CMP_W-1:0]));

  // one-clock wait stretcher
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      waitReg <= 1'b0;
    end else if (strobes.clearWait) begin
      waitReg <= 1'b0;
    end else begin
      waitReg <= strobes.startWait;
    end
  end

  assign waitN = !waitReg;

endmodule

// File: rtl/io_write_aligner_ctrl.sv
module io_write_aligner_ctrl
  import io_write_aligner_pkg::*;
(
  input  logic         clk,
  input  logic         rstN,
  input  logic         fetchStart,
  input  logic         ioWrStart,
  input  logic         opIsPrefix,
  input  logic         opIsTrap,
  input  logic         phaseIsOdd,
  output ctrlStrobes_t strobes
);

  trapState_t state;
  trapState_t stateNext;

  always_comb begin
    stateNext = state;
    if (fetchStart) begin
      if (opIsPrefix) begin
        stateNext = ST_PREFIX;
      end else if (state == ST_PREFIX && opIsTrap) begin
        stateNext = ST_ARMED;
      end else begin
        stateNext = ST_IDLE;
      end
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state <= ST_IDLE;
    end else begin
      state <= stateNext;
    end
  end

  always_comb begin
    strobes.startWait = (state == ST_ARMED) && ioWrStart && phaseIsOdd;
    strobes.clearWait = fetchStart;
  end

endmodule

// File: rtl/io_write_aligner.sv
module io_write_aligner
  import io_write_aligner_pkg::*;
#(
  parameter int          DATA_W     = 8,
  parameter logic [7:0]  PREFIX_OP  = 8'hED,
  parameter logic [7:0]  TRAP_MATCH = 8'hA3,
  parameter logic [7:0]  TRAP_MASK  = 8'hE7,
  parameter logic        ODD_LEVEL  = 1'b1
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              m1N,
  input  logic              mreqN,
  input  logic              iorqN,
  input  logic              rdN,
  input  logic              wrN,
  input  logic [DATA_W-1:0] dataIn,
  input  logic              phaseOdd,
  output logic              waitN
);

  ctrlStrobes_t strobes;
  logic fetchStart;
  logic ioWrStart;
  logic opIsPrefix;
  logic opIsTrap;
  logic phaseIsOdd;

  io_write_aligner_dp #(
    .DATA_W    (DATA_W),
    .PREFIX_OP (PREFIX_OP),
    .TRAP_MATCH(TRAP_MATCH),
    .TRAP_MASK (TRAP_MASK),
    .ODD_LEVEL (ODD_LEVEL)
  ) u_dp (
    .clk       (clk),
    .rstN      (rstN),
    .m1N       (m1N),
    .mreqN     (mreqN),
    .iorqN     (iorqN),
    .rdN       (rdN),
    .wrN       (wrN),
    .dataIn    (dataIn),
    .phaseOdd  (phaseOdd),
    .strobes   (strobes),
    .fetchStart(fetchStart),
    .ioWrStart (ioWrStart),
    .opIsPrefix(opIsPrefix),
    .opIsTrap  (opIsTrap),
    .phaseIsOdd(phaseIsOdd),
    .waitN     (waitN)
  );

  io_write_aligner_ctrl u_ctrl (
    .clk       (clk),
    .rstN      (rstN),
    .fetchStart(fetchStart),
    .ioWrStart (ioWrStart),
    .opIsPrefix(opIsPrefix),
    .opIsTrap  (opIsTrap),
    .phaseIsOdd(phaseIsOdd),
    .strobes   (strobes)
  );

endmodule

// File: rtl/io_write_aligner_chk.sv
module io_write_aligner_chk (
  input logic clk,
  input logic rstN,
  input logic m1N,
  input logic iorqN,
  input logic wrN,
  input logic phaseOdd,
  input logic waitN
);

  // R1
  always @(posedge clk) begin
    if (!rstN) begin
      reset_wait_high_chk: assert (waitN);
    end
  end

  // R2
  wait_cause_chk: assert property (@(posedge clk) disable iff (!rstN)
    $fell(waitN) |-> $past(m1N && !iorqN && !wrN));

  // R3
  wait_one_clk_chk: assert property (@(posedge clk) disable iff (!rstN)
    !waitN |=> waitN);

  // R4
  wait_odd_only_chk: assert property (@(posedge clk) disable iff (!rstN)
    $fell(waitN) |-> $past(phaseOdd));

  // R9
  ack_no_wait_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!m1N && !iorqN) |=> waitN);

endmodule

bind io_write_aligner io_write_aligner_chk u_chk (
  .clk     (clk),
  .rstN    (rstN),
  .m1N     (m1N),
  .iorqN   (iorqN),
  .wrN     (wrN),
  .phaseOdd(phaseOdd),
  .waitN   (waitN)
);

// File: tb/io_write_aligner_tb.sv
`timescale 1ns/1ps
module io_write_aligner_tb;

  typedef struct {
    bit    expLow;
    string tag;
  } expItem_t;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic m1N = 1'b1;
  logic mreqN = 1'b1;
  logic iorqN = 1'b1;
  logic rdN = 1'b1;
  logic wrN = 1'b1;
  logic [7:0] dataIn = 8'h00;
  logic phaseOdd = 1'b0;
  logic waitN;

  bit tOdd = 1'b0;
  int checks = 0;
  int fails = 0;
  bit done = 1'b0;
  expItem_t q[$];

  always #2.5 clk = ~clk;

  io_write_aligner u_dut (
    .clk(clk), .rstN(rstN), .m1N(m1N), .mreqN(mreqN), .iorqN(iorqN),
    .rdN(rdN), .wrN(wrN), .dataIn(dataIn), .phaseOdd(phaseOdd), .waitN(waitN)
  );

  // monitor: one expectation per clock edge
  initial begin
    forever begin
      @(posedge clk);
      #1;
      if (q.size() > 0) begin
        expItem_t it;
        it = q.pop_front();
        checks++;
        if (waitN !== !it.expLow) begin
          fails++;
          $display("FAIL %s: waitN=%b expected %b at %0t", it.tag, waitN, !it.expLow, $time);
        end
      end
    end
  end

  task automatic cyc(input bit m1, input bit mreq, input bit iorq, input bit rd,
                     input bit wr, input logic [7:0] d, input bit expLow, input string tag);
    expItem_t it;
    @(negedge clk);
    m1N = m1; mreqN = mreq; iorqN = iorq; rdN = rd; wrN = wr; dataIn = d;
    phaseOdd = tOdd;
    tOdd = ~tOdd;
    it.expLow = expLow;
    it.tag = tag;
    q.push_back(it);
  endtask

  task automatic idle(input int n, input string tag);
    for (int i = 0; i < n; i++) cyc(1, 1, 1, 1, 1, 8'h00, 0, tag);
  endtask

  task automatic fetch(input logic [7:0] op, input string tag);
    cyc(0, 0, 1, 0, 1, op, 0, tag);
    cyc(0, 0, 1, 0, 1, op, 0, tag);
    idle(2, tag);
  endtask

  // line up so the next driven clock has the wanted parity
  task automatic align(input bit wantOdd);
    if (tOdd != wantOdd) idle(1, "align");
  endtask

  // write held three clocks; wait expected only on the first clock's result
  task automatic ioWrite(input bit trapped, input string tag);
    bit e;
    e = trapped && tOdd;
    cyc(1, 1, 0, 1, 0, 8'h55, e, tag);
    cyc(1, 1, 0, 1, 0, 8'h55, 0, tag);
    cyc(1, 1, 0, 1, 0, 8'h55, 0, tag);
    idle(1, tag);
  endtask

  task automatic intAck(input string tag);
    cyc(0, 1, 0, 1, 1, 8'hFF, 0, tag);
    cyc(0, 1, 0, 1, 1, 8'hFF, 0, tag);
    idle(1, tag);
  endtask

  task automatic doReset(input string tag);
    expItem_t it;
    @(negedge clk);
    rstN = 1'b0;
    it.expLow = 0; it.tag = tag; q.push_back(it);
    idle(2, tag);
    @(negedge clk);
    rstN = 1'b1;
    it.expLow = 0; it.tag = tag; q.push_back(it);
  endtask

  initial begin
    // R1: reset state
    idle(3, "R1");
    @(negedge clk); rstN = 1'b1;
    idle(1, "R1");
    ioWrite(0, "R1");

    // R2 / R3: single output, odd-phase write
    fetch(8'hED, "R2"); fetch(8'hA3, "R2");
    align(1); ioWrite(1, "R2_R3");
    fetch(8'hED, "R2"); fetch(8'hAB, "R2");
    align(1); ioWrite(1, "R2_R3");

    // R4: even-phase write
    fetch(8'hED, "R4"); fetch(8'hA3, "R4");
    align(0); ioWrite(0, "R4");

    // R5: plain prefixed output
    fetch(8'hED, "R5"); fetch(8'h41, "R5");
    align(1); ioWrite(0, "R5");
    fetch(8'hED, "R5"); fetch(8'h79, "R5");
    align(1); ioWrite(0, "R5");

    // R6: no prefix, and broken prefix
    fetch(8'hA3, "R6"); align(1); ioWrite(0, "R6");
    fetch(8'hED, "R6"); fetch(8'h00, "R6"); fetch(8'hB3, "R6");
    align(1); ioWrite(0, "R6");

    // R7: repeating output, three iterations
    for (int k = 0; k < 3; k++) begin
      fetch(8'hED, "R7"); fetch(8'hB3, "R7");
      align(1); ioWrite(1, "R7");
    end
    fetch(8'hED, "R7"); fetch(8'hBB, "R7");
    align(1); ioWrite(1, "R7");

    // R8: other fetch disarms
    fetch(8'hED, "R8"); fetch(8'hA3, "R8");
    align(1); ioWrite(1, "R8");
    fetch(8'h00, "R8"); align(1); ioWrite(0, "R8");

    // R9: acknowledge while armed, then armed write still works
    fetch(8'hED, "R9"); fetch(8'hAB, "R9");
    align(1); intAck("R9");
    align(1); ioWrite(1, "R9");

    // R10: reset between fetch and write
    fetch(8'hED, "R10"); fetch(8'hA3, "R10");
    doReset("R10");
    align(1); ioWrite(0, "R10");

    idle(3, "end");
    while (q.size() > 0) @(negedge clk);
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog: run hung, actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

endmodule